// File: doc/BRIEF.md
# Packet-Splitting Endpoint Transmit Loader

This block moves a block of bytes, whose length software programs, from a valid/ready byte stream into the transmit FIFO of one endpoint. It cuts the block into packets no larger than the endpoint's maximum packet size. A packet is loaded only while the FIFO is free, which means the transmit-ready flag is clear. When auto-arm is enabled, the loader sets the ready flag itself as soon as a full maximum-size packet is in the FIFO. A short final packet is never armed by hardware.

When the last byte of the block has been accepted, a sticky completion interrupt is raised. Host software then finishes the transfer by hand. If the final packet was short, a host arm sends it. If the final packet was full and has already gone out, a host arm sends a zero-length packet that marks the end of the transfer. With auto-arm disabled, the loader stops after every packet until the host arms it and the transmitter has drained it.

Top module: `tx_pkt_loader`

## Requirements
- R1: After reset, src_ready, fifo_wr, tx_rdy, irq and busy are all 0.
- R2: src_ready is 1 only while a transfer is in progress and tx_rdy is 0. No byte is taken from the source while a packet is armed.
- R3: Each byte accepted on the source (src_valid and src_ready both 1 at a clock edge) appears on fifo_wdata with fifo_wr = 1 in the next cycle, in the order accepted.
- R4: With auto_arm = 1 latched at start, accepting the byte that completes a packet of max_pkt bytes sets tx_rdy in the next cycle, with tx_len = max_pkt.
- R5: A final packet shorter than max_pkt leaves tx_rdy at 0. A later host_arm sets tx_rdy with tx_len equal to the number of bytes in that packet.
- R6: Packet boundaries fall every max_pkt bytes. max_pkt (8 to 1024) and auto_arm are sampled at the accepted start.
- R7: After a full final packet has been auto-armed and reported sent, a host_arm sets tx_rdy with tx_len = 0, which is a zero-length packet.
- R8: With auto_arm = 0, hardware never sets tx_rdy. After each packet, src_ready stays 0 until the host arms the packet and pkt_sent clears tx_rdy.
- R9: pkt_sent clears tx_rdy. host_arm has no effect while tx_rdy is 1 or while bytes of a packet are being loaded.
- R10: irq rises in the cycle after the last byte is accepted, and busy falls in the same cycle. irq stays at 1 until an irq_clr pulse clears it. A new completion in the same cycle as irq_clr leaves irq at 1.
- R11: A start with blk_len = 0 raises irq in the next cycle, loads no byte and leaves busy at 0. A following host_arm gives tx_len = 0.
- R12: start is ignored while busy is 1. The running transfer keeps its byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| blk_len | input | 16 | Block length in bytes |
| max_pkt | input | 11 | Maximum packet size in bytes (8 to 1024) |
| auto_arm | input | 1 | Hardware arms full packets when 1 |
| host_arm | input | 1 | Host write that sets the ready flag |
| irq_clr | input | 1 | Write-one-to-clear for irq |
| pkt_sent | input | 1 | Transmitter reports the armed packet sent |
| src_valid | input | 1 | Source byte valid |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Loader accepts a byte |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write byte |
| tx_rdy | output | 1 | Packet armed for transmission |
| tx_len | output | 11 | Length of the armed packet (0 means a zero-length packet) |
| irq | output | 1 | Sticky completion interrupt |
| busy | output | 1 | Transfer in progress |

## Verification
If the in-packet byte count goes wrong, tx_rdy rises one or more cycles away from the max_pkt boundary. A wrong count also shows up as a wrong tx_len at the next host arm, so the reference compare catches it on the first misplaced edge. A bad remaining-length count shows up as irq and busy changing at the wrong accepted byte, or as extra or missing fifo_wr strobes. A lost fill count shows up only at a host arm, as a wrong short-packet length or as a zero-length packet that is not zero. The bench therefore arms by hand after both short and full endings.

// File: rtl/tpl_pkg.sv
package tpl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_HOLD = 2'd2
  } tpl_state_e;
endpackage

// File: rtl/tpl_byte_count.sv
module tpl_byte_count #(
  parameter int LEN_W = 16,
  parameter int MPS_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [MPS_W-1:0] max_pkt,
  input  logic             beat,
  output logic             pkt_full,
  output logic             blk_last,
  output logic [MPS_W-1:0] max_q
);
  logic [LEN_W-1:0] rem_q;
  logic [MPS_W-1:0] pcnt_q;

  assign pkt_full = (pcnt_q + MPS_W'(1)) == max_q;
  assign blk_last = rem_q == LEN_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      pcnt_q <= '0;
      max_q  <= '0;
    end else if (load) begin
      rem_q  <= blk_len;
      pcnt_q <= '0;
      max_q  <= max_pkt;
    end else if (beat) begin
      rem_q  <= rem_q - LEN_W'(1);
      pcnt_q <= (pkt_full || blk_last) ? '0 : pcnt_q + MPS_W'(1);
    end
  end

  // R12
  rem_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    beat |-> rem_q != '0);

  // R6
  pkt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    beat |-> pcnt_q < max_q);
endmodule

// File: rtl/tpl_ready_flag.sv
module tpl_ready_flag #(
  parameter int MPS_W   = 11,
  parameter int MPS_MAX = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hw_arm,
  input  logic             host_ok,
  input  logic             pkt_sent,
  input  logic             beat,
  input  logic [MPS_W-1:0] max_q,
  output logic             tx_rdy,
  output logic [MPS_W-1:0] tx_len
);
  logic [MPS_W-1:0] fill_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_rdy <= 1'b0;
      tx_len <= '0;
      fill_q <= '0;
    end else if (!tx_rdy) begin
      if (hw_arm) begin
        tx_rdy <= 1'b1;
        tx_len <= max_q;
        fill_q <= '0;
      end else if (host_ok) begin
        tx_rdy <= 1'b1;
        tx_len <= fill_q;
        fill_q <= '0;
      end else if (beat) begin
        fill_q <= fill_q + MPS_W'(1);
      end
    end else if (pkt_sent) begin
      tx_rdy <= 1'b0;
    end
  end

  // R4
  arm_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_rdy) |-> $past(hw_arm || host_ok));

  // R9
  rdy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_rdy && !pkt_sent |=> tx_rdy);

  // R6
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    tx_rdy |-> tx_len <= MPS_W'(MPS_MAX));
endmodule

// File: rtl/tx_pkt_loader.sv
module tx_pkt_loader
  import tpl_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 16,
  parameter int MPS_MAX = 1024,
  localparam int MPS_W  = $clog2(MPS_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  blk_len,
  input  logic [MPS_W-1:0]  max_pkt,
  input  logic              auto_arm,
  input  logic              host_arm,
  input  logic              irq_clr,
  input  logic              pkt_sent,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_wdata,
  output logic              tx_rdy,
  output logic [MPS_W-1:0]  tx_len,
  output logic              irq,
  output logic              busy
);
  tpl_state_e       st_q;
  logic             auto_q;
  logic             beat, load, empty_go, done;
  logic             hw_arm, host_ok;
  logic             pkt_full, blk_last;
  logic [MPS_W-1:0] max_q;

  assign src_ready = (st_q == ST_LOAD) && !tx_rdy;
  assign beat      = src_valid && src_ready;
  assign load      = start && (st_q == ST_IDLE) && (blk_len != '0);
  assign empty_go  = start && (st_q == ST_IDLE) && (blk_len == '0);
  assign done      = (beat && blk_last) || empty_go;
  assign hw_arm    = beat && pkt_full && auto_q;
  assign host_ok   = host_arm && (st_q != ST_LOAD);
  assign busy      = st_q != ST_IDLE;

  tpl_byte_count #(.LEN_W(LEN_W), .MPS_W(MPS_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .blk_len  (blk_len),
    .max_pkt  (max_pkt),
    .beat     (beat),
    .pkt_full (pkt_full),
    .blk_last (blk_last),
    .max_q    (max_q)
  );

  tpl_ready_flag #(.MPS_W(MPS_W), .MPS_MAX(MPS_MAX)) u_flag (
    .clk      (clk),
    .rst      (rst),
    .hw_arm   (hw_arm),
    .host_ok  (host_ok),
    .pkt_sent (pkt_sent),
    .beat     (beat),
    .max_q    (max_q),
    .tx_rdy   (tx_rdy),
    .tx_len   (tx_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      auto_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (load) begin
          st_q   <= ST_LOAD;
          auto_q <= auto_arm;
        end
        ST_LOAD: if (beat && (pkt_full || blk_last)) begin
          if (blk_last)             st_q <= ST_IDLE;
          else if (pkt_full && auto_q) st_q <= ST_LOAD;
          else                      st_q <= ST_HOLD;
        end
        ST_HOLD: if (tx_rdy) st_q <= ST_LOAD;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_wr    <= 1'b0;
      fifo_wdata <= '0;
      irq        <= 1'b0;
    end else begin
      fifo_wr <= beat;
      if (beat) fifo_wdata <= src_data;
      if (done)         irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    irq && !irq_clr |=> irq);

  // R10
  irq_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> irq && !busy);

  // R2
  no_load_when_armed_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> !$past(tx_rdy));

  // R8
  manual_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD) && !tx_rdy |=> !fifo_wr);
endmodule

// File: tb/sim_tx_pkt_loader.sv
module sim_tx_pkt_loader;
  localparam int LW = 16;
  localparam int MW = 11;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          start = 0, auto_arm = 0, host_arm = 0, irq_clr = 0, pkt_sent = 0, src_valid = 0;
  logic [LW-1:0] blk_len = 0;
  logic [MW-1:0] max_pkt = 8;
  logic [DW-1:0] src_data = 0;
  logic          src_ready, fifo_wr, tx_rdy, irq, busy;
  logic [DW-1:0] fifo_wdata;
  logic [MW-1:0] tx_len;

  tx_pkt_loader u0 (
    .clk(clk), .rst(rst), .start(start), .blk_len(blk_len), .max_pkt(max_pkt),
    .auto_arm(auto_arm), .host_arm(host_arm), .irq_clr(irq_clr), .pkt_sent(pkt_sent),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .tx_rdy(tx_rdy), .tx_len(tx_len),
    .irq(irq), .busy(busy)
  );

  int total = 0;
  int bad   = 0;
  int wr_count = 0;
  bit cmp_on = 0, src_en = 0, gaps = 0, tx_en = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_st = 0, m_rem = 0, m_pc = 0, m_max = 0, m_fill = 0, m_len = 0, m_wd = 0;
  bit m_auto = 0, m_rdy = 0, m_irq = 0, m_wr = 0, m_beat = 0;

  always @(posedge clk) begin : model
    int o_st;
    bit o_rdy, srdy, beat, hok, full, last, done;
    if (rst) begin
      m_st = 0; m_rem = 0; m_pc = 0; m_max = 0; m_fill = 0; m_len = 0;
      m_auto = 0; m_rdy = 0; m_irq = 0; m_wr = 0; m_beat = 0;
    end else begin
      o_st = m_st; o_rdy = m_rdy;
      srdy = (o_st == 1) && !o_rdy;
      beat = src_valid && srdy;
      hok  = host_arm && !o_rdy && (o_st != 1);
      full = 0; last = 0; done = 0;
      if (beat) begin
        m_pc++; m_rem--;
        full = (m_pc == m_max);
        last = (m_rem == 0);
      end
      case (o_st)
        0: if (start) begin
          if (blk_len == 0) done = 1;
          else begin
            m_st = 1; m_rem = int'(blk_len); m_pc = 0;
            m_max = int'(max_pkt); m_auto = auto_arm;
          end
        end
        1: if (full || last) begin
          m_pc = 0;
          if (last) begin m_st = 0; done = 1; end
          else if (full && m_auto) m_st = 1;
          else m_st = 2;
        end
        default: if (o_rdy) m_st = 1;
      endcase
      if (!o_rdy) begin
        if (beat && full && m_auto) begin m_rdy = 1; m_len = m_max; m_fill = 0; end
        else if (hok) begin m_rdy = 1; m_len = m_fill; m_fill = 0; end
        else if (beat) m_fill++;
      end else if (pkt_sent) m_rdy = 0;
      m_wr = beat;
      if (beat) m_wd = int'(src_data);
      if (done) m_irq = 1;
      else if (irq_clr) m_irq = 0;
      m_beat = beat;
    end
  end

  // compare with the model every cycle
  always @(negedge clk) begin
    if (!rst && cmp_on) begin
      chk("R2 src_ready", int'(src_ready), int'((m_st == 1) && !m_rdy));
      chk("R3 fifo_wr", int'(fifo_wr), int'(m_wr));
      if (m_wr) chk("R3 fifo_wdata", int'(fifo_wdata), m_wd);
      chk("R4 tx_rdy", int'(tx_rdy), int'(m_rdy));
      if (m_rdy) chk("R6 tx_len", int'(tx_len), m_len);
      chk("R10 irq", int'(irq), int'(m_irq));
      chk("R12 busy", int'(busy), int'(m_st != 0));
    end
    if (fifo_wr) wr_count++;
  end

  // byte source
  int gap_cnt = 0;
  always @(negedge clk) begin
    gap_cnt++;
    if (m_beat) src_data = src_data + 8'd1;
    src_valid = src_en && (!gaps || (gap_cnt % 3 != 0));
  end

  // transmitter: reports sent three cycles after arming
  int dly = 0;
  always @(negedge clk) begin
    if (tx_en && tx_rdy && !pkt_sent) begin
      dly++;
      if (dly >= 3) begin pkt_sent = 1; dly = 0; end
    end else pkt_sent = 0;
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic begin_xfer(input int len, input int mps, input bit aa);
    blk_len = LW'(len); max_pkt = MW'(mps); auto_arm = aa; start = 1;
    tick(); start = 0;
  endtask

  task automatic pulse_arm();
    host_arm = 1; tick(); host_arm = 0;
  endtask

  task automatic clear_irq();
    irq_clr = 1; tick(); irq_clr = 0;
  endtask

  task automatic wait_idle();
    while (busy) tick();
  endtask

  task automatic wait_unarmed();
    while (tx_rdy) tick();
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin : main
    int base;
    tick(4);
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 tx_rdy", int'(tx_rdy), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 src_ready", int'(src_ready), 0);
    chk("R1 fifo_wr", int'(fifo_wr), 0);
    cmp_on = 1; src_en = 1;

    // auto-arm, short last packet: 8+8+4, source with gaps
    gaps = 1; tx_en = 1; base = wr_count;
    begin_xfer(20, 8, 1);
    blk_len = 5; start = 1; tick(); start = 0;   // R12 ignored while busy
    wait_idle();
    chk("R10 irq after last byte", int'(irq), 1);
    tick(8);
    chk("R12 bytes of running block", wr_count - base, 20);
    chk("R5 short last not armed", int'(tx_rdy), 0);
    tx_en = 0;
    pulse_arm();
    chk("R5 host arm sets rdy", int'(tx_rdy), 1);
    chk("R5 short length", int'(tx_len), 4);
    tx_en = 1; wait_unarmed();
    tick(2);
    chk("R10 irq still set", int'(irq), 1);
    clear_irq();
    chk("R10 irq cleared", int'(irq), 0);

    // auto-arm, full last packet then zero-length packet
    gaps = 0; base = wr_count;
    begin_xfer(16, 8, 1);
    wait_idle();
    tick();
    chk("R4 full last armed", int'(tx_rdy), 1);
    chk("R4 full length", int'(tx_len), 8);
    wait_unarmed();
    tx_en = 0;
    pulse_arm();
    chk("R7 zlp armed", int'(tx_rdy), 1);
    chk("R7 zlp length", int'(tx_len), 0);
    tx_en = 1; wait_unarmed();
    clear_irq();

    // manual arming: 8 then 4
    tx_en = 0; base = wr_count;
    begin_xfer(12, 8, 0);
    while (wr_count - base < 8) tick();
    tick(6);
    chk("R8 no hardware arm", int'(tx_rdy), 0);
    chk("R8 loader holds", int'(src_ready), 0);
    chk("R8 bytes so far", wr_count - base, 8);
    pulse_arm();
    chk("R8 host arm length", int'(tx_len), 8);
    pulse_arm();
    chk("R9 arm ignored while armed", int'(tx_len), 8);
    tick(3);
    chk("R9 still armed without sent", int'(tx_rdy), 1);
    tx_en = 1;
    wait_idle();
    tick(6);
    chk("R8 last unarmed", int'(tx_rdy), 0);
    tx_en = 0;
    pulse_arm();
    chk("R5 manual short length", int'(tx_len), 4);
    tx_en = 1; wait_unarmed();
    clear_irq();

    // larger packets, host arm during loading is ignored: 16+16+8
    gaps = 1; base = wr_count;
    begin_xfer(40, 16, 1);
    tick(2);
    pulse_arm();
    chk("R9 arm ignored while loading", int'(tx_rdy), 0);
    wait_idle();
    tick(8);
    chk("R6 bytes with mps 16", wr_count - base, 40);
    chk("R5 short last mps 16", int'(tx_rdy), 0);
    tx_en = 0;
    pulse_arm();
    chk("R6 last length mps 16", int'(tx_len), 8);
    tx_en = 1; wait_unarmed();
    clear_irq();

    // zero-length block
    base = wr_count; tx_en = 0;
    begin_xfer(0, 8, 1);
    chk("R11 irq at once", int'(irq), 1);
    chk("R11 not busy", int'(busy), 0);
    tick(3);
    chk("R11 no bytes", wr_count - base, 0);
    pulse_arm();
    chk("R11 zlp length", int'(tx_len), 0);
    chk("R11 zlp armed", int'(tx_rdy), 1);
    tx_en = 1; wait_unarmed();
    clear_irq();
    tick(4);
    finish_run();
  end
endmodule